// File: doc/BRIEF.md
# Reference Clock Switch Sequencer

This block moves a transceiver PLL onto a different logical reference clock. It does so by issuing accesses on a word-wide, memory-mapped reconfiguration bus. A user asks for a switch with a single-cycle request and a logical clock index. The sequencer checks the index against the number of clocks the instance was built with, then asks for the bus and waits for a grant. It then makes three accesses in a fixed order:

1. It reads the per-clock lookup register, which holds the 8-bit physical code for the chosen clock.
2. It reads the clock selection register.
3. It writes the selection register back with only its low byte replaced by that code.

After the final write, the sequencer releases the bus and pulses done. A request with an index the instance cannot serve makes no bus access. Instead, it ends with a one-cycle error pulse.

The configured clock count is the parameter `NUM_CLKS`, with a range of 1 to 5. Preparation and completion around the switch are reduced to a bus request and grant pair.

Top module: `refclk_switch_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `sw_busy`, `sw_done`, `sw_err`, `arb_req`, `bus_read` and `bus_write` are all low.
- R2: A request whose 3-bit index is greater than or equal to `NUM_CLKS` (indices 5 to 7 with the default count of 5) raises `sw_err` for exactly one cycle, in the cycle after the request. In that case `sw_busy` and `arb_req` stay low, and no bus access occurs.
- R3: When `NUM_CLKS` is 1, every request, including index 0, ends as in R2.
- R4: A valid request raises `sw_busy` and `arb_req` in the cycle after it. No bus access is issued before `arb_gnt` has been seen high.
- R5: The first access of a switch to clock n is a read of the lookup register at address 0x113 + n. Its bits [7:0] are taken as the physical code.
- R6: The second access is a read of the selection register at 0x112. The third is a write to 0x112 whose data keeps bits [31:8] of that read and carries the code in bits [7:0]. Exactly three accesses are made per switch.
- R7: While `bus_wait` is high, an issued read or write stays asserted with unchanged address and write data. An access completes on a cycle where it is asserted and `bus_wait` is low, and read data is taken on that cycle.
- R8: In the cycle after the write completes, `sw_done` is high for one cycle, while `sw_busy` and `arb_req` are low. `sw_busy` never falls without `sw_done`.
- R9: Requests that arrive while `sw_busy` or `sw_done` is high are ignored. They change neither the accesses of the running switch nor add any later access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Switch request, one cycle |
| sw_idx | input | 3 | Logical clock index for the request |
| sw_busy | output | 1 | Switch in progress |
| sw_done | output | 1 | One-cycle completion pulse |
| sw_err | output | 1 | One-cycle rejection pulse |
| arb_req | output | 1 | Request for the reconfiguration bus |
| arb_gnt | input | 1 | Bus granted |
| bus_addr | output | 12 | Word address |
| bus_read | output | 1 | Read strobe |
| bus_write | output | 1 | Write strobe |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid when a read completes |
| bus_wait | input | 1 | Slave stall; holds the current access |

## Verification
The hardest situation to reach is the interplay of stalls with data capture. If the read data were taken on a stalled cycle instead of the completing one, a wrong code or a wrong upper word would reach the write. Stalls are also where a dropped strobe would show.

The bench answers from a register model that is filled with fresh random words before every switch. It asserts `bus_wait` at random on about half the cycles and delays the grant by a random number of cycles. It also fires stray requests with other indices in the middle of running switches. Each switch is then checked access by access, and the final contents of 0x112 are compared with a value computed from the model.

// File: rtl/refclk_sw_pkg.sv
package refclk_sw_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int CODE_W   = 8;
    localparam int IDX_W    = 3;
    localparam int MAX_CLKS = 5;

    localparam logic [ADDR_W-1:0] SEL_ADDR = 12'h112;
    localparam logic [ADDR_W-1:0] LUT_BASE = 12'h113;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_LUT_RD,
        ST_SEL_RD,
        ST_SEL_WR,
        ST_DONE
    } sw_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE
    } bus_op_e;

    typedef struct packed {
        bus_op_e             op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } bus_cmd_t;

    function automatic logic [ADDR_W-1:0] lut_addr(input logic [IDX_W-1:0] idx);
        return LUT_BASE + ADDR_W'(idx);
    endfunction

    function automatic logic [DATA_W-1:0] merge_code(input logic [DATA_W-1:0] old_word,
                                                     input logic [CODE_W-1:0] code);
        return {old_word[DATA_W-1:CODE_W], code};
    endfunction

endpackage

// File: rtl/rcs_req_check.sv
module rcs_req_check
    import refclk_sw_pkg::*;
#(
    parameter int NUM_CLKS = MAX_CLKS
) (
    input  logic [IDX_W-1:0] idx,
    output logic             idx_ok
);
    localparam int CNT_W = IDX_W + 1;

    generate
        if (NUM_CLKS < 2) begin : g_single
            // R3: one configured clock leaves nothing to switch to
            assign idx_ok = 1'b0;
        end else begin : g_multi
            assign idx_ok = (CNT_W'(idx) < CNT_W'(NUM_CLKS));
        end
    endgenerate
endmodule

// File: rtl/rcs_bus_port.sv
module rcs_bus_port
    import refclk_sw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_cmd_t           cmd,
    input  logic               bus_wait,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_read,
    output logic               bus_write,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               ack,
    output logic [DATA_W-1:0]  rdata
);
    assign bus_read  = (cmd.op == OP_READ);
    assign bus_write = (cmd.op == OP_WRITE);
    assign bus_addr  = cmd.addr;
    assign bus_wdata = bus_write ? cmd.wdata : '0;
    assign ack       = (bus_read || bus_write) && !bus_wait;
    assign rdata     = bus_rdata;

    // R7: a stalled access is held unchanged
    a_r7_hold_read: assert property (@(posedge clk) disable iff (rst)
        (bus_read && bus_wait) |=> (bus_read && $stable(bus_addr)));
    a_r7_hold_write: assert property (@(posedge clk) disable iff (rst)
        (bus_write && bus_wait) |=> (bus_write && $stable(bus_addr) && $stable(bus_wdata)));
    // R6: every write targets the selection register
    a_r6_write_target: assert property (@(posedge clk) disable iff (rst)
        bus_write |-> (bus_addr == SEL_ADDR));
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bus_read && bus_write));
endmodule

// File: rtl/rcs_seq_fsm.sv
module rcs_seq_fsm
    import refclk_sw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [IDX_W-1:0]   idx,
    input  logic               idx_ok,
    input  logic               arb_gnt,
    input  logic               ack,
    input  logic [DATA_W-1:0]  rdata,
    output bus_cmd_t           cmd,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               arb_req
);
    sw_state_e           state;
    logic [IDX_W-1:0]    idx_q;
    logic [CODE_W-1:0]   code_q;
    logic [DATA_W-1:0]   word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            err    <= 1'b0;
            idx_q  <= '0;
            code_q <= '0;
            word_q <= '0;
        end else begin
            err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        if (idx_ok) begin
                            idx_q <= idx;
                            state <= ST_ARB;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                ST_ARB: begin
                    if (arb_gnt) state <= ST_LUT_RD;
                end
                ST_LUT_RD: begin
                    if (ack) begin
                        code_q <= rdata[CODE_W-1:0];
                        state  <= ST_SEL_RD;
                    end
                end
                ST_SEL_RD: begin
                    if (ack) begin
                        word_q <= merge_code(rdata, code_q);
                        state  <= ST_SEL_WR;
                    end
                end
                ST_SEL_WR: begin
                    if (ack) state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd = '{op: OP_NONE, addr: '0, wdata: '0};
        unique case (state)
            ST_LUT_RD: cmd = '{op: OP_READ,  addr: lut_addr(idx_q), wdata: '0};
            ST_SEL_RD: cmd = '{op: OP_READ,  addr: SEL_ADDR,        wdata: '0};
            ST_SEL_WR: cmd = '{op: OP_WRITE, addr: SEL_ADDR,        wdata: word_q};
            default:   cmd = '{op: OP_NONE,  addr: '0,              wdata: '0};
        endcase
    end

    assign busy    = (state == ST_ARB) || (state == ST_LUT_RD) ||
                     (state == ST_SEL_RD) || (state == ST_SEL_WR);
    assign arb_req = busy;
    assign done    = (state == ST_DONE);

    // R8: busy only ends through a done pulse
    a_r8_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R2: a rejection leaves the bus alone
    a_r2_err_quiet: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !arb_req && cmd.op == OP_NONE));
    a_r2_err_single: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
    // R4: no access outside the bus ownership window
    a_r4_access_owned: assert property (@(posedge clk) disable iff (rst)
        (cmd.op != OP_NONE) |-> arb_req);
    a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err}));
endmodule

// File: rtl/refclk_switch_seq.sv
module refclk_switch_seq
    import refclk_sw_pkg::*;
#(
    parameter int NUM_CLKS = MAX_CLKS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_req,
    input  logic [IDX_W-1:0]   sw_idx,
    output logic               sw_busy,
    output logic               sw_done,
    output logic               sw_err,
    output logic               arb_req,
    input  logic               arb_gnt,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_read,
    output logic               bus_write,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_wait
);
    logic              idx_ok;
    logic              ack;
    logic [DATA_W-1:0] rdata;
    bus_cmd_t          cmd;

    rcs_req_check #(.NUM_CLKS(NUM_CLKS)) u_check (
        .idx    (sw_idx),
        .idx_ok (idx_ok)
    );

    rcs_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (sw_req),
        .idx     (sw_idx),
        .idx_ok  (idx_ok),
        .arb_gnt (arb_gnt),
        .ack     (ack),
        .rdata   (rdata),
        .cmd     (cmd),
        .busy    (sw_busy),
        .done    (sw_done),
        .err     (sw_err),
        .arb_req (arb_req)
    );

    rcs_bus_port u_port (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .bus_wait  (bus_wait),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_read  (bus_read),
        .bus_write (bus_write),
        .bus_wdata (bus_wdata),
        .ack       (ack),
        .rdata     (rdata)
    );
endmodule

// File: tb/refclk_switch_seq_test.sv
module refclk_switch_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_req = 1'b0;
    logic [2:0]  sw_idx = '0;
    logic        sw_busy, sw_done, sw_err, arb_req;
    logic        arb_gnt = 1'b0;
    logic [11:0] bus_addr;
    logic        bus_read, bus_write;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_wait = 1'b0;

    // second instance built with a single configured clock
    logic        s_req = 1'b0;
    logic [2:0]  s_idx = '0;
    logic        s_busy, s_done, s_err, s_arb;
    logic [11:0] s_addr;
    logic        s_rd, s_wr;
    logic [31:0] s_wdata;

    int errors = 0;
    int checks = 0;

    logic [31:0] lut_word [5];
    logic [31:0] sel_reg;
    int          acc_n;
    logic [11:0] acc_addr [8];
    logic        acc_wr   [8];
    logic [31:0] acc_data [8];
    int          wait_pct;
    logic        prev_stall;
    logic [11:0] prev_addr;
    logic        prev_wr;

    always #4 clk = ~clk;

    refclk_switch_seq uut (
        .clk(clk), .rst(rst), .sw_req(sw_req), .sw_idx(sw_idx),
        .sw_busy(sw_busy), .sw_done(sw_done), .sw_err(sw_err),
        .arb_req(arb_req), .arb_gnt(arb_gnt), .bus_addr(bus_addr),
        .bus_read(bus_read), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_wait(bus_wait)
    );

    refclk_switch_seq #(.NUM_CLKS(1)) uut1 (
        .clk(clk), .rst(rst), .sw_req(s_req), .sw_idx(s_idx),
        .sw_busy(s_busy), .sw_done(s_done), .sw_err(s_err),
        .arb_req(s_arb), .arb_gnt(1'b1), .bus_addr(s_addr),
        .bus_read(s_rd), .bus_write(s_wr), .bus_wdata(s_wdata),
        .bus_rdata(32'h0000_00FF), .bus_wait(1'b0)
    );

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == 12'h112) return sel_reg;
        if (a >= 12'h113 && a <= 12'h117) return lut_word[a - 12'h113];
        return 32'hBAD0_0000;
    endfunction

    function automatic logic [31:0] expect_sel(input logic [31:0] old_sel, input logic [31:0] lut);
        return {old_sel[31:8], lut[7:0]};
    endfunction

    assign bus_rdata = model_read(bus_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // bus responder, stall generator and arbiter
    always @(negedge clk) begin
        if (rst) begin
            bus_wait   = 1'b0;
            arb_gnt    = 1'b0;
            prev_stall = 1'b0;
        end else begin
            bus_wait = (($urandom % 100) < wait_pct);
            if (prev_stall) begin
                // R7: access held while stalled
                check((bus_read || bus_write) && bus_addr == prev_addr && bus_write == prev_wr,
                      "R7", "stalled access held", {19'd0, bus_write, bus_addr}, {19'd0, prev_wr, prev_addr});
            end
            if (bus_read || bus_write) begin
                check(arb_gnt, "R4", "access while granted", {31'd0, arb_gnt}, 32'd1);
                if (!bus_wait) begin
                    if (acc_n < 8) begin
                        acc_addr[acc_n] = bus_addr;
                        acc_wr[acc_n]   = bus_write;
                        acc_data[acc_n] = bus_write ? bus_wdata : bus_rdata;
                    end
                    acc_n++;
                    if (bus_write && bus_addr == 12'h112) sel_reg = bus_wdata;
                end
            end
            prev_stall = (bus_read || bus_write) && bus_wait;
            prev_addr  = bus_addr;
            prev_wr    = bus_write;
            if (!arb_req) arb_gnt = 1'b0;
            else if (!arb_gnt && ($urandom % 3 == 0)) arb_gnt = 1'b1;
        end
    end

    task automatic expect_reject(input logic [2:0] idx, input string req);
        int start_n = acc_n;
        sw_req = 1'b1; sw_idx = idx;
        @(negedge clk);
        sw_req = 1'b0;
        check(sw_err && !sw_busy && !arb_req, req, "rejection pulse",
              {29'd0, sw_err, sw_busy, arb_req}, 32'h4);
        @(negedge clk);
        check(!sw_err && !sw_busy && !arb_req, req, "rejection is one cycle",
              {29'd0, sw_err, sw_busy, arb_req}, 32'h0);
        repeat (3) @(negedge clk);
        check(acc_n == start_n, req, "no bus access on rejection", acc_n, start_n);
    endtask

    task automatic run_switch(input logic [2:0] idx, input bit stray);
        logic [31:0] old_sel;
        int          cyc = 0;
        for (int i = 0; i < 5; i++) lut_word[i] = $urandom;
        sel_reg = $urandom;
        old_sel = sel_reg;
        acc_n   = 0;
        sw_req = 1'b1; sw_idx = idx;
        @(negedge clk);
        sw_req = 1'b0;
        check(sw_busy && arb_req && !sw_done, "R4", "busy and bus request after request",
              {29'd0, sw_busy, arb_req, sw_done}, 32'h6);
        while (!sw_done && cyc < 400) begin
            if (stray && (cyc % 4 == 1)) begin sw_req = 1'b1; sw_idx = idx ^ 3'd1; end
            else sw_req = 1'b0;
            @(negedge clk);
            cyc++;
        end
        sw_req = stray;   // request during the done cycle is ignored too
        sw_idx = 3'd0;
        check(sw_done && !sw_busy && !arb_req, "R8", "done pulse with bus released",
              {29'd0, sw_done, sw_busy, arb_req}, 32'h4);
        @(negedge clk);
        sw_req = 1'b0;
        check(!sw_done, "R8", "done lasts one cycle", {31'd0, sw_done}, 32'd0);
        repeat (4) @(negedge clk);
        check(!sw_busy, "R9", "stray request did not start a switch", {31'd0, sw_busy}, 32'd0);
        check(acc_n == 3, "R6", "three accesses", acc_n, 32'd3);
        if (acc_n >= 3) begin
            check(!acc_wr[0] && acc_addr[0] == 12'h113 + 12'(idx), "R5", "lookup read address",
                  {19'd0, acc_wr[0], acc_addr[0]}, 32'h113 + 32'(idx));
            check(!acc_wr[1] && acc_addr[1] == 12'h112, "R6", "selection read",
                  {19'd0, acc_wr[1], acc_addr[1]}, 32'h112);
            check(acc_wr[2] && acc_addr[2] == 12'h112, "R6", "selection write",
                  {19'd0, acc_wr[2], acc_addr[2]}, 32'h1112);
            check(acc_data[2] == expect_sel(old_sel, lut_word[idx]), "R7", "write data from captured reads",
                  acc_data[2], expect_sel(old_sel, lut_word[idx]));
        end
        check(sel_reg == expect_sel(old_sel, lut_word[idx]), "R6", "final selection register",
              sel_reg, expect_sel(old_sel, lut_word[idx]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_pct = 0;
        acc_n = 0;
        sel_reg = 32'h0;
        for (int i = 0; i < 5; i++) lut_word[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        check(!sw_busy && !sw_done && !sw_err && !arb_req && !bus_read && !bus_write,
              "R1", "idle during reset",
              {26'd0, sw_busy, sw_done, sw_err, arb_req, bus_read, bus_write}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!sw_busy && !sw_done && !sw_err && !arb_req && !bus_read && !bus_write,
              "R1", "idle after reset",
              {26'd0, sw_busy, sw_done, sw_err, arb_req, bus_read, bus_write}, 32'd0);

        // directed boundaries without stalls
        run_switch(3'd0, 1'b0);
        run_switch(3'd4, 1'b0);
        expect_reject(3'd5, "R2");
        expect_reject(3'd7, "R2");

        // R3: single-clock instance rejects index 0
        s_req = 1'b1; s_idx = 3'd0;
        @(negedge clk);
        s_req = 1'b0;
        check(s_err && !s_busy && !s_arb, "R3", "single clock rejects",
              {29'd0, s_err, s_busy, s_arb}, 32'h4);
        repeat (3) @(negedge clk);
        check(!s_rd && !s_wr && !s_busy && !s_err, "R3", "single clock stays off the bus",
              {28'd0, s_rd, s_wr, s_busy, s_err}, 32'd0);

        // heavy stalls, stray requests in flight (R7, R9)
        wait_pct = 60;
        run_switch(3'd2, 1'b1);
        run_switch(3'd4, 1'b1);

        // constrained random mix
        for (int n = 0; n < 30; n++) begin
            logic [2:0] ri;
            ri = 3'($urandom % 8);
            wait_pct = int'($urandom % 80);
            if (ri < 3'd5) run_switch(ri, n[0]);
            else expect_reject(ri, "R2");
            repeat (int'($urandom % 3)) @(negedge clk);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule